// File: doc/BRIEF.md
# Memory-to-Stream Burst DMA Engine

This engine moves a fixed-size buffer between a memory-mapped AXI master port and an AXI4-Stream port. A build-time parameter fixes the direction. With `TO_STREAM = 1` the engine issues read bursts and forwards each returned word onto the outgoing stream. With `TO_STREAM = 0` it takes words from the incoming stream and writes them to memory with write bursts. Each start command carries a base address, a repetition count and an addressing mode. Every repetition moves one whole buffer of `BUF_BEATS` interface words.

In increment mode each repetition carries on from the address where the previous buffer ended, so consecutive repetitions cover consecutive buffers. In wrap mode every repetition begins again at the base address, which replays one constant buffer (a weight table, for example) as many times as needed. The engine cuts each buffer into INCR bursts. No burst is longer than `MAX_BURST` beats and no burst crosses a 4 KB address page. The engine keeps one burst in flight at a time. A single-cycle done pulse marks the end of the last repetition.

Top module: `mm_stream_dma`

## Requirements
- R1: In the read direction, returned words appear on the stream in address order. Stream valid follows read-data valid, and read-data ready is asserted only while the stream consumer is ready. Every read burst is INCR (burst code 2'b01) with a size code equal to log2 of the word size in bytes. The address and length stay steady while the address request waits for ready.
- R2: In increment mode, repetition k (counting from 0) begins at base + k * BUF_BEATS * bytes-per-word.
- R3: In wrap mode, every repetition begins at the base address and issues the same burst sequence.
- R4: No burst is longer than MAX_BURST beats. A buffer that is larger is split into several bursts that together hold exactly BUF_BEATS beats.
- R5: No burst crosses a 4096-byte address boundary: the page offset plus the burst's byte length is at most 4096.
- R6: In the write direction, a burst's write address is accepted before any of its data beats. The data beats carry the stream words in order. The last-beat flag is high only on the final beat of each burst, and no data is presented after that beat until the next address is accepted.
- R7: In the write direction, done is raised only after the write response for every issued burst has been accepted.
- R8: busy is high from the cycle after an accepted start until done. done is high for exactly one cycle, and busy is low in the cycle that follows it.
- R9: A start that arrives while busy is ignored. The running job completes with its original address, count and mode, and no extra bursts follow it.
- R10: A start with a repetition count of zero issues no burst and raises done in the cycle after the start.
- R11: During reset, every valid output, read-data ready, busy and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, accepted only when idle |
| start_base | input | ADDR_W | Byte base address of the buffer, word aligned |
| start_reps | input | REP_W | Number of buffer repetitions |
| start_wrap | input | 1 | 1 = wrap mode, 0 = increment mode |
| busy | output | 1 | A job is running |
| done | output | 1 | One-cycle pulse when the job ends |
| ar_valid | output | 1 | Read address valid |
| ar_ready | input | 1 | Read address ready |
| ar_addr | output | ADDR_W | Read burst start address |
| ar_len | output | 8 | Read burst beats minus one |
| ar_size | output | 3 | Read beat size code |
| ar_burst | output | 2 | Read burst type (INCR) |
| r_valid | input | 1 | Read data valid |
| r_ready | output | 1 | Read data ready |
| r_data | input | DATA_W | Read data |
| r_last | input | 1 | Last read beat (informational) |
| aw_valid | output | 1 | Write address valid |
| aw_ready | input | 1 | Write address ready |
| aw_addr | output | ADDR_W | Write burst start address |
| aw_len | output | 8 | Write burst beats minus one |
| aw_size | output | 3 | Write beat size code |
| aw_burst | output | 2 | Write burst type (INCR) |
| w_valid | output | 1 | Write data valid |
| w_ready | input | 1 | Write data ready |
| w_data | output | DATA_W | Write data |
| w_strb | output | DATA_W/8 | Write byte strobes, all set |
| w_last | output | 1 | Final beat of the write burst |
| b_valid | input | 1 | Write response valid |
| b_ready | output | 1 | Write response ready |
| s_tvalid | input | 1 | Incoming stream valid |
| s_tready | output | 1 | Incoming stream ready |
| s_tdata | input | DATA_W | Incoming stream data |
| m_tvalid | output | 1 | Outgoing stream valid |
| m_tready | input | 1 | Outgoing stream ready |
| m_tdata | output | DATA_W | Outgoing stream data |

## Verification
Five properties are checked on every cycle: bursts never cross a page and never exceed the length cap, a pending address request holds steady, stream back-pressure always reaches read-data ready, no write data appears between a burst's last beat and the next address, and done is a single-cycle pulse. The bench scenarios cover what only a complete job can show: the whole burst sequence for each base address and mode, the order of data words over several repetitions, an ignored restart, a zero-count job, and done waiting behind the final write response.

// File: rtl/mm_dma_pkg.sv
package mm_dma_pkg;

  localparam int PAGE_BYTES = 4096;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_RESP,
    ST_FIN
  } dma_state_e;

  // Words that still fit before the next page boundary.
  function automatic int beats_to_page(input logic [11:0] page_off, input int bytes);
    return (PAGE_BYTES - int'(page_off)) / bytes;
  endfunction

  // Burst length: the smallest of what is left, the room in the page and the cap.
  function automatic int burst_beats(input int left, input int room, input int cap);
    int n;
    n = left;
    if (n > cap)  n = cap;
    if (n > room) n = room;
    return n;
  endfunction

endpackage

// File: rtl/mm_dma_burst_planner.sv
module mm_dma_burst_planner #(
  parameter int ADDR_W    = 32,
  parameter int BYTES     = 4,
  parameter int BUF_BEATS = 64,
  parameter int MAX_BURST = 256,
  parameter int REP_W     = 16,
  localparam int LEN_W    = $clog2(MAX_BURST + 1),
  localparam int BL_W     = $clog2(BUF_BEATS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic [REP_W-1:0]  reps,
  input  logic              wrap,
  input  logic              advance,
  output logic [ADDR_W-1:0] addr,
  output logic [LEN_W-1:0]  len,
  output logic              last_burst
);
  import mm_dma_pkg::*;

  logic [ADDR_W-1:0] cur_addr, base_q;
  logic [BL_W-1:0]   beats_left;
  logic [REP_W-1:0]  reps_left;
  logic              wrap_q;
  int                len_int;
  logic              buf_end;
  logic [ADDR_W-1:0] next_seq;

  assign len_int    = burst_beats(int'(beats_left), beats_to_page(cur_addr[11:0], BYTES), MAX_BURST);
  assign len        = LEN_W'(len_int);
  assign addr       = cur_addr;
  assign buf_end    = (int'(beats_left) == len_int);
  assign next_seq   = cur_addr + ADDR_W'(len_int * BYTES);
  assign last_burst = buf_end && (reps_left == REP_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr   <= '0;
      base_q     <= '0;
      beats_left <= '0;
      reps_left  <= '0;
      wrap_q     <= 1'b0;
    end else if (load) begin
      cur_addr   <= base;
      base_q     <= base;
      beats_left <= BL_W'(BUF_BEATS);
      reps_left  <= reps;
      wrap_q     <= wrap;
    end else if (advance) begin
      if (buf_end) begin
        reps_left  <= reps_left - REP_W'(1);
        beats_left <= BL_W'(BUF_BEATS);
        cur_addr   <= wrap_q ? base_q : next_seq;
      end else begin
        beats_left <= beats_left - BL_W'(len_int);
        cur_addr   <= next_seq;
      end
    end
  end

endmodule

// File: rtl/mm_dma_beat_counter.sv
module mm_dma_beat_counter #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  input  logic             step,
  output logic             last
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= len;
    else if (step) cnt <= cnt - CNT_W'(1);
  end

  assign last = (cnt == CNT_W'(1));

endmodule

// File: rtl/mm_stream_dma.sv
module mm_stream_dma #(
  parameter bit TO_STREAM = 1'b1,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int BUF_BEATS = 64,
  parameter int MAX_BURST = 256,
  parameter int REP_W     = 16,
  localparam int BYTES     = DATA_W / 8,
  localparam int SIZE_CODE = $clog2(BYTES),
  localparam int LEN_W     = $clog2(MAX_BURST + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_base,
  input  logic [REP_W-1:0]  start_reps,
  input  logic              start_wrap,
  output logic              busy,
  output logic              done,
  output logic              ar_valid,
  input  logic              ar_ready,
  output logic [ADDR_W-1:0] ar_addr,
  output logic [7:0]        ar_len,
  output logic [2:0]        ar_size,
  output logic [1:0]        ar_burst,
  input  logic              r_valid,
  output logic              r_ready,
  input  logic [DATA_W-1:0] r_data,
  input  logic              r_last,
  output logic              aw_valid,
  input  logic              aw_ready,
  output logic [ADDR_W-1:0] aw_addr,
  output logic [7:0]        aw_len,
  output logic [2:0]        aw_size,
  output logic [1:0]        aw_burst,
  output logic              w_valid,
  input  logic              w_ready,
  output logic [DATA_W-1:0] w_data,
  output logic [BYTES-1:0]  w_strb,
  output logic              w_last,
  input  logic              b_valid,
  output logic              b_ready,
  input  logic              s_tvalid,
  output logic              s_tready,
  input  logic [DATA_W-1:0] s_tdata,
  output logic              m_tvalid,
  input  logic              m_tready,
  output logic [DATA_W-1:0] m_tdata
);
  import mm_dma_pkg::*;

  dma_state_e        state, state_nx;
  logic              in_addr, in_data, in_resp;
  logic              addr_rdy, addr_hs, beat_hs, beat_last, resp_hs;
  logic              plan_load, plan_last, final_q;
  logic [ADDR_W-1:0] plan_addr;
  logic [LEN_W-1:0]  plan_len;
  logic [7:0]        len_field;
  logic              unused_inputs;

  assign unused_inputs = ^{r_last, r_valid, r_data, ar_ready, aw_ready, w_ready,
                           b_valid, s_tvalid, s_tdata, m_tready};

  assign in_addr   = (state == ST_ADDR);
  assign in_data   = (state == ST_DATA);
  assign in_resp   = (state == ST_RESP);
  assign addr_hs   = in_addr && addr_rdy;
  assign resp_hs   = in_resp && b_valid;
  assign plan_load = (state == ST_IDLE) && start;
  assign len_field = 8'(plan_len - LEN_W'(1));
  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_FIN);

  mm_dma_burst_planner #(
    .ADDR_W(ADDR_W), .BYTES(BYTES), .BUF_BEATS(BUF_BEATS),
    .MAX_BURST(MAX_BURST), .REP_W(REP_W)
  ) u_planner (
    .clk(clk), .rst_n(rst_n), .load(plan_load), .base(start_base),
    .reps(start_reps), .wrap(start_wrap), .advance(addr_hs),
    .addr(plan_addr), .len(plan_len), .last_burst(plan_last)
  );

  mm_dma_beat_counter #(.CNT_W(LEN_W)) u_beats (
    .clk(clk), .rst_n(rst_n), .load(addr_hs), .len(plan_len),
    .step(beat_hs), .last(beat_last)
  );

  generate
    if (TO_STREAM) begin : g_read
      assign ar_valid = in_addr;
      assign ar_addr  = plan_addr;
      assign ar_len   = len_field;
      assign ar_size  = 3'(SIZE_CODE);
      assign ar_burst = 2'b01;
      assign addr_rdy = ar_ready;
      assign r_ready  = in_data && m_tready;
      assign m_tvalid = in_data && r_valid;
      assign m_tdata  = r_data;
      assign beat_hs  = in_data && r_valid && m_tready;
      assign aw_valid = 1'b0;
      assign aw_addr  = '0;
      assign aw_len   = '0;
      assign aw_size  = '0;
      assign aw_burst = '0;
      assign w_valid  = 1'b0;
      assign w_data   = '0;
      assign w_strb   = '0;
      assign w_last   = 1'b0;
      assign b_ready  = 1'b0;
      assign s_tready = 1'b0;
    end else begin : g_write
      assign aw_valid = in_addr;
      assign aw_addr  = plan_addr;
      assign aw_len   = len_field;
      assign aw_size  = 3'(SIZE_CODE);
      assign aw_burst = 2'b01;
      assign addr_rdy = aw_ready;
      assign w_valid  = in_data && s_tvalid;
      assign s_tready = in_data && w_ready;
      assign w_data   = s_tdata;
      assign w_strb   = {BYTES{1'b1}};
      assign w_last   = in_data && beat_last;
      assign b_ready  = in_resp;
      assign beat_hs  = in_data && s_tvalid && w_ready;
      assign ar_valid = 1'b0;
      assign ar_addr  = '0;
      assign ar_len   = '0;
      assign ar_size  = '0;
      assign ar_burst = '0;
      assign r_ready  = 1'b0;
      assign m_tvalid = 1'b0;
      assign m_tdata  = '0;
    end
  endgenerate

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE: if (start) state_nx = (start_reps == '0) ? ST_FIN : ST_ADDR;
      ST_ADDR: if (addr_hs) state_nx = ST_DATA;
      ST_DATA: if (beat_hs && beat_last) begin
        if (!TO_STREAM)   state_nx = ST_RESP;
        else if (final_q) state_nx = ST_FIN;
        else              state_nx = ST_ADDR;
      end
      ST_RESP: if (resp_hs) state_nx = final_q ? ST_FIN : ST_ADDR;
      ST_FIN:  state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      final_q <= 1'b0;
    end else begin
      state <= state_nx;
      if (addr_hs) final_q <= plan_last;
    end
  end

endmodule

// File: rtl/mm_dma_checker.sv
module mm_dma_checker #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int MAX_BURST = 256,
  localparam int BYTES    = DATA_W / 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done,
  input logic              ar_valid,
  input logic              ar_ready,
  input logic [ADDR_W-1:0] ar_addr,
  input logic [7:0]        ar_len,
  input logic              aw_valid,
  input logic [ADDR_W-1:0] aw_addr,
  input logic [7:0]        aw_len,
  input logic              r_ready,
  input logic              m_tvalid,
  input logic              m_tready,
  input logic              r_valid,
  input logic              w_valid,
  input logic              w_ready,
  input logic              w_last
);

  a_r5_read_page: assert property (@(posedge clk) disable iff (!rst_n)
    ar_valid |-> (int'(ar_addr[11:0]) + (int'(ar_len) + 1) * BYTES) <= 4096);

  a_r5_write_page: assert property (@(posedge clk) disable iff (!rst_n)
    aw_valid |-> (int'(aw_addr[11:0]) + (int'(aw_len) + 1) * BYTES) <= 4096);

  a_r4_len_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (ar_valid || aw_valid) |-> (int'(ar_len) < MAX_BURST && int'(aw_len) < MAX_BURST));

  a_r1_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ar_valid && !ar_ready |=> ar_valid && $stable(ar_addr) && $stable(ar_len));

  a_r1_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    (r_ready |-> m_tready) and (m_tvalid |-> r_valid));

  a_r6_gap_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    w_valid && w_ready && w_last |=> !w_valid);

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind mm_stream_dma mm_dma_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_BURST(MAX_BURST)
) u_dma_checker (
  .clk(clk), .rst_n(rst_n), .done(done),
  .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr), .ar_len(ar_len),
  .aw_valid(aw_valid), .aw_addr(aw_addr), .aw_len(aw_len),
  .r_ready(r_ready), .m_tvalid(m_tvalid), .m_tready(m_tready), .r_valid(r_valid),
  .w_valid(w_valid), .w_ready(w_ready), .w_last(w_last)
);

// File: tb/mm_stream_dma_bench.sv
module mm_stream_dma_bench;
  localparam int AW = 32, DW = 32, BUF = 20, MAXB = 8, RW = 4, BY = 4;

  // {expected burst count[47:40], base[39:8], reps[7:4], pad[3:2], wrap[1], backpressure[0]}
  localparam logic [47:0] SCN [0:3] = '{
    {8'd6, 32'h0000_1000, 4'd2, 2'b00, 1'b0, 1'b0},
    {8'd6, 32'h0000_1FF0, 4'd2, 2'b00, 1'b1, 1'b1},
    {8'd9, 32'h0000_2FE0, 4'd3, 2'b00, 1'b0, 1'b1},
    {8'd3, 32'h0000_0000, 4'd1, 2'b00, 1'b1, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;

  // read-direction instance signals
  logic          rd_start = 0, rd_wrap = 0;
  logic [AW-1:0] rd_base = '0;
  logic [RW-1:0] rd_reps = '0;
  logic          rd_busy, rd_done;
  logic          rd_ar_valid, rd_ar_ready = 0;
  logic [AW-1:0] rd_ar_addr;
  logic [7:0]    rd_ar_len;
  logic [2:0]    rd_ar_size;
  logic [1:0]    rd_ar_burst;
  logic          rd_r_valid = 0, rd_r_ready, rd_r_last = 0;
  logic [DW-1:0] rd_r_data = '0;
  logic          rd_aw_valid, rd_w_valid, rd_w_last, rd_b_ready, rd_s_tready;
  logic [AW-1:0] rd_aw_addr;
  logic [7:0]    rd_aw_len;
  logic [2:0]    rd_aw_size;
  logic [1:0]    rd_aw_burst;
  logic [DW-1:0] rd_w_data;
  logic [BY-1:0] rd_w_strb;
  logic          rd_m_tvalid, rd_m_tready = 0;
  logic [DW-1:0] rd_m_tdata;

  // write-direction instance signals
  logic          wr_start = 0;
  logic [AW-1:0] wr_base = '0;
  logic [RW-1:0] wr_reps = '0;
  logic          wr_busy, wr_done;
  logic          wr_ar_valid, wr_r_ready, wr_m_tvalid;
  logic [AW-1:0] wr_ar_addr;
  logic [7:0]    wr_ar_len;
  logic [2:0]    wr_ar_size;
  logic [1:0]    wr_ar_burst;
  logic [DW-1:0] wr_m_tdata;
  logic          wr_aw_valid, wr_aw_ready = 0;
  logic [AW-1:0] wr_aw_addr;
  logic [7:0]    wr_aw_len;
  logic [2:0]    wr_aw_size;
  logic [1:0]    wr_aw_burst;
  logic          wr_w_valid, wr_w_ready = 0, wr_w_last;
  logic [DW-1:0] wr_w_data;
  logic [BY-1:0] wr_w_strb;
  logic          wr_b_valid = 0, wr_b_ready;
  logic          wr_s_tvalid = 0, wr_s_tready;
  logic [DW-1:0] wr_s_tdata = '0;

  mm_stream_dma #(.TO_STREAM(1'b1), .ADDR_W(AW), .DATA_W(DW), .BUF_BEATS(BUF),
                  .MAX_BURST(MAXB), .REP_W(RW)) u_mm_stream_dma (
    .clk(clk), .rst_n(rst_n), .start(rd_start), .start_base(rd_base),
    .start_reps(rd_reps), .start_wrap(rd_wrap), .busy(rd_busy), .done(rd_done),
    .ar_valid(rd_ar_valid), .ar_ready(rd_ar_ready), .ar_addr(rd_ar_addr),
    .ar_len(rd_ar_len), .ar_size(rd_ar_size), .ar_burst(rd_ar_burst),
    .r_valid(rd_r_valid), .r_ready(rd_r_ready), .r_data(rd_r_data), .r_last(rd_r_last),
    .aw_valid(rd_aw_valid), .aw_ready(1'b0), .aw_addr(rd_aw_addr), .aw_len(rd_aw_len),
    .aw_size(rd_aw_size), .aw_burst(rd_aw_burst), .w_valid(rd_w_valid), .w_ready(1'b0),
    .w_data(rd_w_data), .w_strb(rd_w_strb), .w_last(rd_w_last), .b_valid(1'b0),
    .b_ready(rd_b_ready), .s_tvalid(1'b0), .s_tready(rd_s_tready), .s_tdata('0),
    .m_tvalid(rd_m_tvalid), .m_tready(rd_m_tready), .m_tdata(rd_m_tdata)
  );

  mm_stream_dma #(.TO_STREAM(1'b0), .ADDR_W(AW), .DATA_W(DW), .BUF_BEATS(BUF),
                  .MAX_BURST(MAXB), .REP_W(RW)) u_mm_stream_dma_wr (
    .clk(clk), .rst_n(rst_n), .start(wr_start), .start_base(wr_base),
    .start_reps(wr_reps), .start_wrap(1'b0), .busy(wr_busy), .done(wr_done),
    .ar_valid(wr_ar_valid), .ar_ready(1'b0), .ar_addr(wr_ar_addr),
    .ar_len(wr_ar_len), .ar_size(wr_ar_size), .ar_burst(wr_ar_burst),
    .r_valid(1'b0), .r_ready(wr_r_ready), .r_data('0), .r_last(1'b0),
    .aw_valid(wr_aw_valid), .aw_ready(wr_aw_ready), .aw_addr(wr_aw_addr), .aw_len(wr_aw_len),
    .aw_size(wr_aw_size), .aw_burst(wr_aw_burst), .w_valid(wr_w_valid), .w_ready(wr_w_ready),
    .w_data(wr_w_data), .w_strb(wr_w_strb), .w_last(wr_w_last), .b_valid(wr_b_valid),
    .b_ready(wr_b_ready), .s_tvalid(wr_s_tvalid), .s_tready(wr_s_tready), .s_tdata(wr_s_tdata),
    .m_tvalid(wr_m_tvalid), .m_tready(1'b1), .m_tdata(wr_m_tdata)
  );

  // shared logs (only one instance runs at a time)
  int g_addr [0:63];
  int g_len  [0:63];
  int g_n = 0;
  logic [DW-1:0] d_log [0:255];
  int d_n = 0;
  int e_addr [0:63];
  int e_len  [0:63];
  int e_n = 0;
  bit size_bad = 0, bp_bad = 0, bp_mode = 0;

  // read-side memory model
  bit rd_act = 0;
  int rd_cnt = 0;
  logic [AW-1:0] rd_cur = '0;

  // write-side memory model
  bit wr_act = 0, b_pend = 0, wd_bad = 0, last_bad = 0, early_w = 0;
  int wr_cnt = 0, b_dly = 0, b_n = 0, wd_n = 0, src_idx = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog: run did not complete (actual %0d cycles, expected fewer)", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  always @(posedge clk) begin
    if (rd_ar_valid && rd_ar_ready) begin
      if (g_n < 64) begin g_addr[g_n] = int'(rd_ar_addr); g_len[g_n] = int'(rd_ar_len) + 1; end
      g_n++;
      if (rd_ar_size != 3'd2 || rd_ar_burst != 2'b01) size_bad = 1;
      rd_act = 1; rd_cur = rd_ar_addr; rd_cnt = int'(rd_ar_len) + 1;
    end
    if (rd_r_valid && rd_r_ready) begin
      rd_cur = rd_cur + 32'd4; rd_cnt--;
      if (rd_cnt == 0) rd_act = 0;
    end
    if (rd_m_tvalid && rd_m_tready) begin
      if (d_n < 256) d_log[d_n] = rd_m_tdata;
      d_n++;
    end
    if (rd_r_ready && !rd_m_tready) bp_bad = 1;

    if (wr_aw_valid && wr_aw_ready) begin
      if (g_n < 64) begin g_addr[g_n] = int'(wr_aw_addr); g_len[g_n] = int'(wr_aw_len) + 1; end
      g_n++;
      wr_act = 1; wr_cnt = int'(wr_aw_len) + 1;
    end
    if (wr_w_valid && !wr_act) early_w = 1;
    if (b_pend && b_dly > 0) b_dly--;
    if (wr_b_valid && wr_b_ready) begin b_pend = 0; b_n++; end
    if (wr_w_valid && wr_w_ready) begin
      if (wr_w_data != DW'(wd_n)) wd_bad = 1;
      if (wr_w_last != (wr_cnt == 1)) last_bad = 1;
      wd_n++; wr_cnt--;
      if (wr_cnt == 0) begin wr_act = 0; b_pend = 1; b_dly = 2; end
    end
    if (wr_s_tvalid && wr_s_tready) src_idx++;
  end

  always @(negedge clk) begin
    rd_ar_ready = !rd_act && (cyc % 2 == 0);
    rd_r_valid  = rd_act;
    rd_r_data   = rd_cur;
    rd_r_last   = rd_act && (rd_cnt == 1);
    rd_m_tready = bp_mode ? (cyc % 3 != 1) : 1'b1;
    wr_aw_ready = !wr_act && !b_pend;
    wr_w_ready  = wr_act && (cyc % 4 != 2);
    wr_b_valid  = b_pend && (b_dly == 0);
    wr_s_tvalid = 1'b1;
    wr_s_tdata  = DW'(src_idx);
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic build_exp(input int base, input int reps, input bit wrap);
    int a, left, room, n;
    e_n = 0;
    for (int r = 0; r < reps; r++) begin
      a = wrap ? base : base + r * BUF * BY;
      left = BUF;
      while (left > 0) begin
        room = (4096 - (a % 4096)) / BY;
        n = left;
        if (n > MAXB) n = MAXB;
        if (n > room) n = room;
        if (e_n < 64) begin e_addr[e_n] = a; e_len[e_n] = n; end
        e_n++; a += n * BY; left -= n;
      end
    end
  endtask

  task automatic cmp_bursts(input string req);
    bit ok;
    int bad_i;
    ok = (g_n == e_n); bad_i = -1;
    for (int i = 0; i < e_n && i < 64; i++)
      if (g_addr[i] != e_addr[i] || g_len[i] != e_len[i]) begin ok = 0; if (bad_i < 0) bad_i = i; end
    chk(ok, req, "burst sequence (count / first bad index)", g_n * 1000 + bad_i, e_n * 1000 - 1);
  endtask

  task automatic cmp_limits();
    bit cap_ok, page_ok;
    cap_ok = 1; page_ok = 1;
    for (int i = 0; i < g_n && i < 64; i++) begin
      if (g_len[i] > MAXB || g_len[i] < 1) cap_ok = 0;
      if ((g_addr[i] % 4096) + g_len[i] * BY > 4096) page_ok = 0;
    end
    chk(cap_ok, "R4", "burst length within cap", cap_ok, 1);
    chk(page_ok, "R5", "no burst crosses a 4 KB page", page_ok, 1);
  endtask

  task automatic wait_done_rd(output int t);
    t = 0;
    while (!rd_done && t < 3000) begin @(negedge clk); t++; end
  endtask

  task automatic run_read(input int base, input int reps, input bit wrap, input bit bp,
                          input int exp_bursts);
    int t, k, total;
    bit ok;
    bp_mode = bp; g_n = 0; d_n = 0; size_bad = 0; bp_bad = 0;
    build_exp(base, reps, wrap);
    @(negedge clk);
    rd_base = AW'(base); rd_reps = RW'(reps); rd_wrap = wrap; rd_start = 1;
    @(negedge clk);
    rd_start = 0;
    chk(rd_busy, "R8", "busy after start", rd_busy, 1);
    wait_done_rd(t);
    chk(rd_done, "R8", "done reached", rd_done, 1);
    @(negedge clk);
    chk(!rd_done && !rd_busy, "R8", "done one cycle then idle", {rd_done, rd_busy}, 0);
    cmp_bursts(wrap ? "R3" : "R2");
    chk(g_n == exp_bursts, "R4", "split burst count from table", g_n, exp_bursts);
    cmp_limits();
    ok = 1; k = 0; total = 0;
    for (int i = 0; i < e_n && i < 64; i++)
      for (int j = 0; j < e_len[i]; j++) begin
        if (k < 256 && d_log[k] != DW'(e_addr[i] + j * BY)) ok = 0;
        k++;
      end
    total = k;
    chk(ok && d_n == total, "R1", "stream words in address order", d_n, total);
    chk(!size_bad, "R1", "burst type and size code", size_bad, 0);
    chk(!bp_bad, "R1", "read ready gated by stream ready", bp_bad, 0);
  endtask

  initial begin
    int t, n0;
    // R11: reset state
    repeat (3) @(negedge clk);
    chk(!rd_ar_valid && !rd_m_tvalid && !rd_r_ready && !wr_aw_valid && !wr_w_valid,
        "R11", "valid outputs low in reset",
        {rd_ar_valid, rd_m_tvalid, rd_r_ready, wr_aw_valid, wr_w_valid}, 0);
    chk(!rd_busy && !rd_done && !wr_busy && !wr_done, "R11", "busy/done low in reset",
        {rd_busy, rd_done, wr_busy, wr_done}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // table-driven read scenarios (R1-R5, R8)
    for (int s = 0; s < 4; s++)
      run_read(int'(SCN[s][39:8]), int'(SCN[s][7:4]), SCN[s][1], SCN[s][0], int'(SCN[s][47:40]));

    // R10: zero repetitions
    g_n = 0;
    @(negedge clk); rd_base = 32'h0000_4000; rd_reps = '0; rd_wrap = 0; rd_start = 1;
    @(negedge clk); rd_start = 0;
    chk(rd_done, "R10", "done one cycle after zero-count start", rd_done, 1);
    @(negedge clk);
    chk(!rd_done && !rd_busy && g_n == 0, "R10", "no burst for zero count", g_n, 0);

    // R9: restart while busy is ignored
    g_n = 0; d_n = 0; bp_mode = 0;
    build_exp(32'h1000, 2, 0);
    @(negedge clk); rd_base = 32'h0000_1000; rd_reps = 4'd2; rd_wrap = 0; rd_start = 1;
    @(negedge clk); rd_start = 0;
    repeat (5) @(negedge clk);
    chk(rd_busy, "R9", "busy before second start", rd_busy, 1);
    rd_base = 32'h0000_6000; rd_reps = 4'd1; rd_wrap = 1; rd_start = 1;
    @(negedge clk); rd_start = 0;
    wait_done_rd(t);
    @(negedge clk);
    cmp_bursts("R9");
    n0 = g_n;
    repeat (20) @(negedge clk);
    chk(g_n == n0 && !rd_busy, "R9", "no bursts after ignored start", g_n, n0);

    // write direction (R6, R7, R2 with page split)
    g_n = 0; wd_n = 0; b_n = 0; wd_bad = 0; last_bad = 0; early_w = 0;
    build_exp(32'h0FF8, 2, 0);
    @(negedge clk); wr_base = 32'h0000_0FF8; wr_reps = 4'd2; wr_start = 1;
    @(negedge clk); wr_start = 0;
    t = 0;
    while (!wr_done && t < 3000) begin @(negedge clk); t++; end
    chk(wr_done, "R8", "write done reached", wr_done, 1);
    chk(!b_pend && b_n == g_n, "R7", "all responses before done", b_n, g_n);
    @(negedge clk);
    chk(!wr_done && !wr_busy, "R8", "write done single cycle", {wr_done, wr_busy}, 0);
    cmp_bursts("R2");
    cmp_limits();
    chk(!wd_bad && wd_n == 2 * BUF, "R6", "stream words written in order", wd_n, 2 * BUF);
    chk(!last_bad, "R6", "last flag on final beat only", last_bad, 0);
    chk(!early_w, "R6", "address accepted before data", early_w, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule